// File: doc/BRIEF.md
# Message-Validated Double-Buffered Output Latch

This block sits between a serial bus terminal and a set of discrete output lines. The terminal hands over each received data word through a plain memory-style write port: an address, a data word and a write strobe. A linear address decode steers the word into one of several holding registers. These holding registers form the first stage.

The discrete outputs are driven by a second bank of registers. That bank changes only when the terminal signals, with a one-cycle pulse, that the whole message arrived intact. On that pulse every holding register is copied into its output register on the same clock edge.

A per-message valid flag is cleared by any word-error pulse. A commit pulse is ignored unless the flag is still set, so a message with any bad word never reaches the outputs. A separate read port returns one of several discrete input words, selected by address. The read port drives its data only while a read of a mapped address is active. The tri-state buffer is modelled as a data word plus an output enable.

Top module: `validated_output_latch`

## Requirements
- R1: After reset, all holding and output registers are zero, `discOut` reads zero and `rdOe` is low.
- R2: A write with `wrAddr` = k, where k < NUM_OUT, loads `wrData` into holding register k only. This becomes visible on output word k (bits k*DATA_W upward of `discOut`) at the next commit.
- R3: A write with `wrAddr` >= NUM_OUT is ignored. It changes no register and does not open a message.
- R4: Writes alone never change `discOut`. The outputs change only on the clock edge where a commit takes place.
- R5: A `blockGood` pulse while the message valid flag is set copies every holding register to its output register on that edge. The result is visible after the edge.
- R6: A `wordErr` pulse clears the valid flag and opens a message if none is open. A later `blockGood` that closes that message leaves `discOut` unchanged.
- R7: The first mapped write after a message closes opens a new message and sets the valid flag again. The next clean `blockGood` then commits.
- R8: Every `blockGood` pulse closes the message and clears the valid flag. A `blockGood` with no mapped write since the previous close, including one right after reset, leaves `discOut` unchanged.
- R9: When `wordErr` and `blockGood` are high in the same cycle, the commit is suppressed.
- R10: `rdOe` is high exactly when `rdEn` is high and `rdAddr` < NUM_IN. While it is high, `rdData` equals input word `rdAddr` of `discIn`. Otherwise `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Word transfer strobe from the terminal |
| wrAddr | input | ADDR_W | Linear address of the holding register |
| wrData | input | DATA_W | Received data word |
| blockGood | input | 1 | One-cycle pulse: message received without error |
| wordErr | input | 1 | One-cycle pulse: error detected on a word of the message |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Discrete input word select |
| discIn | input | NUM_IN*DATA_W | Discrete input words, word i at bits i*DATA_W upward |
| rdData | output | DATA_W | Read data, zero when not driven |
| rdOe | output | 1 | Read data output enable |
| discOut | output | NUM_OUT*DATA_W | Validated output words, word i at bits i*DATA_W upward |

## Verification
The bench steps through a long series of messages with arithmetic data. Each message mixes mapped and unmapped addresses and partial rewrites. The messages also place the error pulse before the first word, mid-message and in the commit cycle itself, and some repeat the commit pulse. A design that copied on every write would move the outputs early. One that failed to clear the flag on close would commit a stale or erroneous message on the repeated pulse. One that let an error in the commit cycle slip through would publish a bad message. The read port is swept over every address with the enable both high and low, which catches an enable that leaks on unmapped addresses or a mux that picks the wrong word.

// File: rtl/vol_pkg.sv
package vol_pkg;
  typedef struct packed {
    logic commit;   // copy holding bank into output bank this edge
    logic wordHit;  // a mapped word is being written this cycle
  } volStb_t;
endpackage

// File: rtl/vol_ctrl.sv
module vol_ctrl
  import vol_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic               blockGood,
  input  logic               wordErr,
  output volStb_t            stb,
  output logic [NUM_OUT-1:0] ldSel
);
  logic msgValid;
  logic msgOpen;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_dec
    assign ldSel[i] = wrEn && (int'(wrAddr) == i);
  end

  assign stb.wordHit = |ldSel;
  assign stb.commit  = blockGood && msgValid && !wordErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      msgOpen  <= 1'b0;
    end else if (blockGood) begin
      msgValid <= 1'b0;
      msgOpen  <= 1'b0;
    end else begin
      if (stb.wordHit && !msgOpen) begin
        msgOpen  <= 1'b1;
        msgValid <= 1'b1;
      end
      if (wordErr) begin
        msgOpen  <= 1'b1;
        msgValid <= 1'b0;
      end
    end
  end

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ldSel));
  p_unmapped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(wrAddr) >= NUM_OUT) |-> (ldSel == '0));
  p_err_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    wordErr |=> !stb.commit);
  p_close_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    blockGood |=> !stb.commit);
endmodule

// File: rtl/vol_datapath.sv
module vol_datapath
  import vol_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int NUM_OUT = 4,
  parameter int NUM_IN  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  volStb_t                   stb,
  input  logic [NUM_OUT-1:0]        ldSel,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      rdEn,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic [NUM_IN*DATA_W-1:0]  discIn,
  output logic [DATA_W-1:0]         rdData,
  output logic                      rdOe,
  output logic [NUM_OUT*DATA_W-1:0] discOut
);
  localparam int FLAT_W = NUM_OUT * DATA_W;

  logic [FLAT_W-1:0] holdFlat;
  logic [FLAT_W-1:0] outFlat;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_word
    logic [DATA_W-1:0] holdReg;
    logic [DATA_W-1:0] outReg;

    always_ff @(posedge clk) begin
      if (!rstN)          holdReg <= '0;
      else if (ldSel[i])  holdReg <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN)          outReg <= '0;
      else if (stb.commit) outReg <= holdReg;
    end

    assign holdFlat[i*DATA_W +: DATA_W] = holdReg;
    assign outFlat[i*DATA_W +: DATA_W]  = outReg;
  end

  assign discOut = outFlat;

  always_comb begin
    rdOe   = rdEn && (int'(rdAddr) < NUM_IN);
    rdData = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (rdOe && int'(rdAddr) == i) rdData = discIn[i*DATA_W +: DATA_W];
    end
  end

  p_out_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(outFlat));
  p_commit_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> (outFlat == $past(holdFlat)));
  p_read_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (!rdOe && rdData == '0));
endmodule

// File: rtl/validated_output_latch.sv
module validated_output_latch
  import vol_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int NUM_OUT = 4,
  parameter int NUM_IN  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      blockGood,
  input  logic                      wordErr,
  input  logic                      rdEn,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic [NUM_IN*DATA_W-1:0]  discIn,
  output logic [DATA_W-1:0]         rdData,
  output logic                      rdOe,
  output logic [NUM_OUT*DATA_W-1:0] discOut
);
  volStb_t            stb;
  logic [NUM_OUT-1:0] ldSel;

  vol_ctrl #(.ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .blockGood(blockGood), .wordErr(wordErr), .stb(stb), .ldSel(ldSel)
  );

  vol_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_OUT(NUM_OUT),
                 .NUM_IN(NUM_IN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ldSel(ldSel), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .discIn(discIn), .rdData(rdData),
    .rdOe(rdOe), .discOut(discOut)
  );
endmodule

// File: tb/validated_output_latch_bench.sv
module validated_output_latch_bench;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NO = 4;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic blockGood = 1'b0;
  logic wordErr = 1'b0;
  logic rdEn = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [NI*DW-1:0] discIn = '0;
  logic [DW-1:0] rdData;
  logic rdOe;
  logic [NO*DW-1:0] discOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DW-1:0] mHold [NO];
  logic [DW-1:0] mOut  [NO];
  bit mValid, mOpen;

  always #2 clk = ~clk;

  validated_output_latch #(.ADDR_W(AW), .DATA_W(DW), .NUM_OUT(NO), .NUM_IN(NI))
    u_validated_output_latch (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .blockGood(blockGood), .wordErr(wordErr), .rdEn(rdEn), .rdAddr(rdAddr),
    .discIn(discIn), .rdData(rdData), .rdOe(rdOe), .discOut(discOut)
  );

  task automatic checkOuts(string tag);
    for (int i = 0; i < NO; i++) begin
      checks++;
      if (discOut[i*DW +: DW] !== mOut[i]) begin
        errors++;
        $display("FAIL %s: output word %0d actual %h expected %h",
                 tag, i, discOut[i*DW +: DW], mOut[i]);
      end
    end
  endtask

  // one cycle of stimulus, driven at negedge, checked at the following negedge
  task automatic step(bit we, int addr, logic [DW-1:0] data, bit good, bit err);
    string tag;
    bit commitNow;
    bit mapped = (addr < NO);
    if (good && err)                 tag = "R9";
    else if (good && mValid)         tag = "R2 R5";
    else if (good && mOpen)          tag = "R6";
    else if (good)                   tag = "R8";
    else if (we && !mapped)          tag = "R3";
    else if (we && !mOpen)           tag = "R7";
    else                             tag = "R4";
    wrEn = we; wrAddr = AW'(addr); wrData = data; blockGood = good; wordErr = err;
    @(negedge clk);
    wrEn = 1'b0; blockGood = 1'b0; wordErr = 1'b0;
    commitNow = good && mValid && !err;
    if (commitNow) for (int i = 0; i < NO; i++) mOut[i] = mHold[i];
    if (we && mapped) mHold[addr] = data;
    if (good) begin
      mValid = 1'b0; mOpen = 1'b0;
    end else begin
      if (we && mapped && !mOpen) begin mOpen = 1'b1; mValid = 1'b1; end
      if (err) begin mOpen = 1'b1; mValid = 1'b0; end
    end
    checkOuts(tag);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NO; i++) begin mHold[i] = '0; mOut[i] = '0; end
    mValid = 1'b0; mOpen = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkOuts("R1");
    checks++;
    if (rdOe !== 1'b0) begin
      errors++;
      $display("FAIL R1: rdOe actual %b expected 0", rdOe);
    end
    // R8: commit pulse right after reset with nothing written
    step(0, 0, '0, 1, 0);
    // R1: single word then commit, other words still zero from reset
    step(1, 2, 16'hA5C3, 0, 0);
    step(0, 0, '0, 1, 0);

    for (int m = 0; m < 40; m++) begin
      int kind = m % 5;
      if (kind == 1) step(0, 0, '0, 0, 1);        // error before first word
      for (int a = 0; a < NO + 2; a++) begin
        if (kind == 4 && a != (m % NO) && a < NO) continue;  // partial rewrite
        step(1, a, DW'(m * 977 + a * 131 + 7), 0, 0);
        if (kind == 2 && a == 1) step(0, 0, '0, 0, 1);        // mid-message error
      end
      if (kind == 3) step(0, 0, '0, 1, 1);       // error coincides with commit
      else           step(0, 0, '0, 1, 0);
      if (m % 4 == 0) step(0, 0, '0, 1, 0);      // repeated commit pulse
      step(1, NO + (m % 3), DW'(m), 0, 0);       // unmapped write between messages
      step(0, 0, '0, 1, 0);
    end

    // R10: read sweep
    for (int i = 0; i < NI; i++) discIn[i*DW +: DW] = DW'(16'h1111 * (i + 1) + 3);
    for (int en = 0; en < 2; en++) begin
      for (int a = 0; a < (1 << AW); a++) begin
        bit expOe;
        logic [DW-1:0] expD;
        @(negedge clk);
        rdEn = en[0]; rdAddr = AW'(a);
        #1;
        expOe = (en == 1) && (a < NI);
        expD  = expOe ? DW'(16'h1111 * (a + 1) + 3) : '0;
        checks++;
        if (rdOe !== expOe || rdData !== expD) begin
          errors++;
          $display("FAIL R10: addr %0d en %0d actual oe=%b data=%h expected oe=%b data=%h",
                   a, en, rdOe, rdData, expOe, expD);
        end
      end
    end
    rdEn = 1'b0;
    @(negedge clk);
    finishRun();
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finishRun();
  end
endmodule